// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block is a synthesizable serial-peripheral slave that looks like a small serial NOR flash to an external master. The serial clock, chip select and data input are synchronized into the system clock domain. Input bits are taken on serial clock rising edges and output bits are launched on falling edges, which is SPI mode 0. The block decodes single-byte opcodes for write enable, status read and write, normal and fast read, page program, sector and bulk erase, identification read, deep power-down and release. The storage is an on-chip byte array with 256-byte pages. The number of pages per sector and the number of sectors are parameters, and the defaults are kept small so the array can be simulated.

Program, erase and status-write operations run as timed internal cycles. A cycle starts only when chip select rises on the exact bit boundary that its opcode requires, and only while the write enable latch is set. During the cycle a walker steps through the affected bytes, and a cycle counter holds the busy flag for at least a configurable time. Page program data is collected in a page buffer with a per-byte mask and is ANDed into the array when the cycle runs.

Top module: `spi_nor_emu`

## Requirements
- R1: Serial input is captured on rising serial clock edges, MSB first. `miso_o` changes only after a synchronized falling edge, or while chip select is high, when it returns to 0.
- R2: Read (03h) takes three address bytes and then returns successive array bytes for as long as chip select stays low. The address wraps from the last array byte to byte 0, and address bits above the array size are ignored.
- R3: Fast read (0Bh) takes three address bytes and one dummy byte, and then returns data as read does.
- R4: Page program (02h) stores old AND new in each written byte, so a program can only clear bits.
- R5: Program data that runs past the end of a page wraps to offset 0 of the same page. Other pages are left unchanged.
- R6: When more than 256 data bytes are sent in one program, each page offset keeps the last byte that was received for it.
- R7: Sector erase (D8h) sets every byte of the addressed sector to FFh, and only when chip select rises right after exactly 32 bits. Any other count leaves the array and the latch unchanged.
- R8: Bulk erase (C7h) sets the whole array to FFh.
- R9: Status bit 0 reads 1 while a program, erase or status-write cycle runs. An identification read during such a cycle returns no data (00h).
- R10: Identification read (9Fh) returns 20h and then 15h.
- R11: Program, erase and status write (01h) start only when status bit 1 (write enable latch, set by 06h) is 1. The latch clears when the cycle ends, and a status write stores bits 7:2.
- R12: After deep power-down (B9h) every opcode except release (ABh) is ignored, including write enable and status read. Release returns to normal operation.
- R13: While a cycle runs, only status read is decoded. Write enable and erase sent during a cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |

## Verification
Programming is tried with four input patterns. A start two bytes before a page end separates in-page wrap from a spill into the next page. A second program over already programmed bytes separates AND from overwrite. A 260-byte burst whose first four bytes differ from the rest separates last-wins from first-wins and from accumulated AND. A one-byte program whose busy window is used to send more commands shows that commands are rejected during a cycle. Sector erase is sent once with a stray ninth address bit and once correctly, and a byte in the other sector shows the erase range. Reads are started at the array end and with high address bits set, which separates wrap-around and address masking from plain sequential reads.

// File: rtl/spi_nor_emu_pkg.sv
package spi_nor_emu_pkg;
  localparam int PAGE_BYTES = 256;
  localparam int PAGE_W     = 8;

  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_SERA  = 8'hD8;
  localparam logic [7:0] OP_BERA  = 8'hC7;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [1:0] {JOB_WRSR, JOB_PROG, JOB_SERA, JOB_BERA} job_e;
endpackage

// File: rtl/spi_nor_emu_sync.sv
module spi_nor_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic cs_high_o,
  output logic mosi_o
);
  // bit 2: sck, bit 1: cs_n, bit 0: mosi
  localparam logic [2:0] IDLE_V = 3'b010;

  logic [2:0] chain [STAGES+1];
  logic [2:0] last_q;

  assign chain[0] = {sck_i, cs_ni, mosi_i};

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= IDLE_V;
      else         chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IDLE_V;
    else         last_q <= chain[STAGES];
  end

  assign sck_rise_o = chain[STAGES][2] & ~last_q[2];
  assign sck_fall_o = ~chain[STAGES][2] & last_q[2];
  assign cs_rise_o  = chain[STAGES][1] & ~last_q[1];
  assign cs_high_o  = chain[STAGES][1];
  assign mosi_o     = chain[STAGES][0];
endmodule

// File: rtl/spi_nor_emu_ctrl.sv
module spi_nor_emu_ctrl
  import spi_nor_emu_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter logic [7:0]  ID_TYPE = 8'h20,
  parameter logic [7:0]  ID_CAP  = 8'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              cs_rise_i,
  input  logic              cs_high_i,
  input  logic              mosi_i,
  input  logic              busy_i,
  input  logic              wel_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [PAGE_W-1:0] pb_idx_i,
  output logic [7:0]        pb_data_o,
  output logic              pb_hit_o,
  output logic              wel_set_o,
  output logic              start_o,
  output job_e              job_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [5:0]        sr_wr_o,
  output logic              sleep_o,
  output logic              miso_o
);
  logic [2:0]            bit_q, byte_q;
  logic [7:0]            rx_q, cmd_q, sr_q, tx_q;
  logic [ADDR_W-1:0]     addr_q, rd_ptr_q;
  logic [PAGE_W-1:0]     wr_off_q;
  logic [PAGE_BYTES-1:0] pmask_q;
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [2:0]            tx_cnt_q;
  logic                  out_en_q, miso_q, sleep_q;

  logic [7:0]        rx_next, next_byte;
  logic [ADDR_W-1:0] addr_full;
  logic              byte_done, op_legal, aligned, pb_we;

  assign rx_next   = {rx_q[6:0], mosi_i};
  assign addr_full = {addr_q[ADDR_W-9:0], rx_next};
  assign byte_done = sck_rise_i && !cs_high_i && (bit_q == 3'd7);
  assign op_legal  = busy_i ? (rx_next == OP_RDSR) : (sleep_q ? (rx_next == OP_WAKE) : 1'b1);
  assign aligned   = (bit_q == 3'd0);
  assign pb_we     = byte_done && (cmd_q == OP_PROG) && (byte_q >= 3'd4);

  always_comb begin
    unique case (cmd_q)
      OP_RDSR:  next_byte = status_i;
      OP_IDENT: next_byte = (rd_ptr_q == '0) ? ID_TYPE :
                            (rd_ptr_q == ADDR_W'(1)) ? ID_CAP : 8'h00;
      default:  next_byte = rd_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0; byte_q <= '0; rx_q <= '0; cmd_q <= OP_NONE; sr_q <= '0;
      tx_q <= '0; addr_q <= '0; rd_ptr_q <= '0; wr_off_q <= '0; pmask_q <= '0;
      tx_cnt_q <= '0; out_en_q <= 1'b0; miso_q <= 1'b0;
    end else if (cs_high_i) begin
      bit_q <= '0; byte_q <= '0; out_en_q <= 1'b0; miso_q <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        rx_q  <= rx_next;
        bit_q <= bit_q + 3'd1;
      end
      if (byte_done) begin
        if (byte_q != 3'd7) byte_q <= byte_q + 3'd1;
        if (byte_q == 3'd0) begin
          cmd_q <= op_legal ? rx_next : OP_NONE;
          if (op_legal && (rx_next == OP_RDSR || rx_next == OP_IDENT)) begin
            out_en_q <= 1'b1; tx_cnt_q <= '0; rd_ptr_q <= '0;
          end
        end
        if (byte_q >= 3'd1 && byte_q <= 3'd3) addr_q <= addr_full;
        if (byte_q == 3'd1 && cmd_q == OP_WRSR) sr_q <= rx_next;
        if (byte_q == 3'd3 && cmd_q == OP_READ) begin
          out_en_q <= 1'b1; tx_cnt_q <= '0; rd_ptr_q <= addr_full;
        end
        if (byte_q == 3'd3 && cmd_q == OP_PROG) begin
          wr_off_q <= addr_full[PAGE_W-1:0];
          pmask_q  <= '0;
        end
        if (byte_q == 3'd4 && cmd_q == OP_FREAD) begin
          out_en_q <= 1'b1; tx_cnt_q <= '0; rd_ptr_q <= addr_q;
        end
        if (pb_we) begin
          pmask_q[wr_off_q] <= 1'b1;
          wr_off_q <= wr_off_q + 1'b1;
        end
      end
      if (sck_fall_i && out_en_q) begin
        tx_cnt_q <= tx_cnt_q + 3'd1;
        if (tx_cnt_q == 3'd0) begin
          miso_q   <= next_byte[7];
          tx_q     <= {next_byte[6:0], 1'b0};
          rd_ptr_q <= rd_ptr_q + 1'b1;
        end else begin
          miso_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (pb_we) pbuf[wr_off_q] <= rx_next;
  end

  // deep power-down entry / exit on exact one-byte frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_q <= 1'b0;
    else if (cs_rise_i && aligned && byte_q == 3'd1 && !busy_i) begin
      if (cmd_q == OP_SLEEP)     sleep_q <= 1'b1;
      else if (cmd_q == OP_WAKE) sleep_q <= 1'b0;
    end
  end

  logic frame_ok;
  assign frame_ok = cs_rise_i && aligned && !busy_i && !sleep_q;

  always_comb begin
    start_o = 1'b0;
    job_o   = JOB_WRSR;
    unique case (cmd_q)
      OP_WRSR: begin start_o = (byte_q == 3'd2); job_o = JOB_WRSR; end
      OP_PROG: begin start_o = (byte_q >= 3'd5); job_o = JOB_PROG; end
      OP_SERA: begin start_o = (byte_q == 3'd4); job_o = JOB_SERA; end
      OP_BERA: begin start_o = (byte_q == 3'd1); job_o = JOB_BERA; end
      default: start_o = 1'b0;
    endcase
    start_o = start_o && frame_ok && wel_i;
  end

  assign wel_set_o = frame_ok && (cmd_q == OP_WREN) && (byte_q == 3'd1);
  assign addr_o    = addr_q;
  assign sr_wr_o   = sr_q[7:2];
  assign rd_addr_o = rd_ptr_q;
  assign pb_data_o = pbuf[pb_idx_i];
  assign pb_hit_o  = pmask_q[pb_idx_i];
  assign sleep_o   = sleep_q;
  assign miso_o    = miso_q;
endmodule

// File: rtl/spi_nor_emu_core.sv
module spi_nor_emu_core
  import spi_nor_emu_pkg::*;
#(
  parameter int SECT_PAGES = 4,
  parameter int SECTORS    = 2,
  parameter int PROG_CYC   = 1000,
  parameter int SERA_CYC   = 1100,
  parameter int BERA_CYC   = 2100,
  parameter int WRSR_CYC   = 400,
  parameter int ADDR_W     = $clog2(PAGE_BYTES * SECT_PAGES * SECTORS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wel_set_i,
  input  logic              start_i,
  input  job_e              job_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [5:0]        sr_wr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [PAGE_W-1:0] pb_idx_o,
  input  logic [7:0]        pb_data_i,
  input  logic              pb_hit_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              wel_o,
  output logic              mem_we_o
);
  localparam int MEM_BYTES = PAGE_BYTES * SECT_PAGES * SECTORS;
  localparam int SECT_W    = $clog2(PAGE_BYTES * SECT_PAGES);
  localparam int LIM_A     = (PROG_CYC > SERA_CYC) ? PROG_CYC : SERA_CYC;
  localparam int LIM_B     = (BERA_CYC > WRSR_CYC) ? BERA_CYC : WRSR_CYC;
  localparam int TMR_W     = $clog2(((LIM_A > LIM_B) ? LIM_A : LIM_B) + 1);

  logic [7:0]        mem [MEM_BYTES];
  logic              busy_q, wel_q, walk_done_q;
  logic [5:0]        sr_bits_q;
  job_e              job_q;
  logic [ADDR_W-1:0] ptr_q, end_q;
  logic [TMR_W-1:0]  tmr_q, lim_q;
  logic [7:0]        mem_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; wel_q <= 1'b0; walk_done_q <= 1'b1; sr_bits_q <= '0;
      job_q <= JOB_WRSR; ptr_q <= '0; end_q <= '0; tmr_q <= '0; lim_q <= '0;
    end else if (start_i) begin
      busy_q      <= 1'b1;
      job_q       <= job_i;
      tmr_q       <= '0;
      walk_done_q <= 1'b0;
      unique case (job_i)
        JOB_PROG: begin
          ptr_q <= {addr_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
          end_q <= {addr_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
          lim_q <= TMR_W'(PROG_CYC);
        end
        JOB_SERA: begin
          ptr_q <= {addr_i[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
          end_q <= {addr_i[ADDR_W-1:SECT_W], {SECT_W{1'b1}}};
          lim_q <= TMR_W'(SERA_CYC);
        end
        JOB_BERA: begin
          ptr_q <= '0; end_q <= '1; lim_q <= TMR_W'(BERA_CYC);
        end
        default: begin
          walk_done_q <= 1'b1; sr_bits_q <= sr_wr_i; lim_q <= TMR_W'(WRSR_CYC);
        end
      endcase
    end else if (busy_q) begin
      if (!walk_done_q) begin
        if (ptr_q == end_q) walk_done_q <= 1'b1;
        else                ptr_q <= ptr_q + 1'b1;
      end
      if (tmr_q != lim_q) tmr_q <= tmr_q + 1'b1;
      else if (walk_done_q) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end
    end else if (wel_set_i) begin
      wel_q <= 1'b1;
    end
  end

  assign pb_idx_o = ptr_q[PAGE_W-1:0];
  assign mem_we_o = busy_q && !walk_done_q && ((job_q == JOB_PROG) ? pb_hit_i : (job_q != JOB_WRSR));
  assign mem_wd   = (job_q == JOB_PROG) ? (mem[ptr_q] & pb_data_i) : 8'hFF;

  always_ff @(posedge clk_i) begin
    if (mem_we_o) mem[ptr_q] <= mem_wd;
  end

  assign rd_data_o = mem[rd_addr_i];
  assign status_o  = {sr_bits_q, wel_q, busy_q};
  assign busy_o    = busy_q;
  assign wel_o     = wel_q;
endmodule

// File: rtl/spi_nor_emu.sv
module spi_nor_emu
  import spi_nor_emu_pkg::*;
#(
  parameter int         SECT_PAGES  = 4,
  parameter int         SECTORS     = 2,
  parameter int         PROG_CYC    = 1000,
  parameter int         SERA_CYC    = 1100,
  parameter int         BERA_CYC    = 2100,
  parameter int         WRSR_CYC    = 400,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_TYPE     = 8'h20,
  parameter logic [7:0] ID_CAP      = 8'h15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int ADDR_W = $clog2(PAGE_BYTES * SECT_PAGES * SECTORS);

  logic sck_rise, sck_fall, cs_rise, cs_high, mosi_s;
  logic busy, wel, wel_set, start, sleep, mem_we, pb_hit;
  job_e job;
  logic [ADDR_W-1:0] addr, rd_addr;
  logic [5:0]        sr_wr;
  logic [7:0]        status, rd_data, pb_data;
  logic [PAGE_W-1:0] pb_idx;

  spi_nor_emu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_rise_o(cs_rise),
    .cs_high_o(cs_high), .mosi_o(mosi_s)
  );

  spi_nor_emu_ctrl #(.ADDR_W(ADDR_W), .ID_TYPE(ID_TYPE), .ID_CAP(ID_CAP)) u_ctrl (
    .clk_i, .rst_ni,
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .cs_rise_i(cs_rise),
    .cs_high_i(cs_high), .mosi_i(mosi_s),
    .busy_i(busy), .wel_i(wel), .status_i(status), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .pb_idx_i(pb_idx), .pb_data_o(pb_data), .pb_hit_o(pb_hit),
    .wel_set_o(wel_set), .start_o(start), .job_o(job), .addr_o(addr),
    .sr_wr_o(sr_wr), .sleep_o(sleep), .miso_o
  );

  spi_nor_emu_core #(
    .SECT_PAGES(SECT_PAGES), .SECTORS(SECTORS), .PROG_CYC(PROG_CYC),
    .SERA_CYC(SERA_CYC), .BERA_CYC(BERA_CYC), .WRSR_CYC(WRSR_CYC), .ADDR_W(ADDR_W)
  ) u_core (
    .clk_i, .rst_ni, .wel_set_i(wel_set), .start_i(start), .job_i(job),
    .addr_i(addr), .sr_wr_i(sr_wr), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pb_idx_o(pb_idx), .pb_data_i(pb_data), .pb_hit_i(pb_hit),
    .status_o(status), .busy_o(busy), .wel_o(wel), .mem_we_o(mem_we)
  );
endmodule

// File: rtl/spi_nor_emu_chk.sv
module spi_nor_emu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic miso_i,
  input logic sck_fall_i,
  input logic cs_high_i,
  input logic start_i,
  input logic wel_i,
  input logic busy_i,
  input logic sleep_i,
  input logic mem_we_i
);
  p_miso_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_i) |-> $past(sck_fall_i || cs_high_i));

  p_start_needs_wel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> wel_i);

  p_wel_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !wel_i);

  p_no_start_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_i);

  p_no_start_sleep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !sleep_i);

  p_write_in_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> busy_i);
endmodule

bind spi_nor_emu spi_nor_emu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miso_i(miso_o), .sck_fall_i(sck_fall),
  .cs_high_i(cs_high), .start_i(start), .wel_i(wel), .busy_i(busy),
  .sleep_i(sleep), .mem_we_i(mem_we)
);

// File: tb/tb_spi_nor_emu.sv
`timescale 1ns/1ps
module tb_spi_nor_emu;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] rbuf [8];
  logic [7:0] tbuf [300];

  always #4 clk = ~clk;

  spi_nor_emu dut (.clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
                   .mosi_i(mosi), .miso_o(miso));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso; sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk); cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xb(op, r); desel();
  endtask

  task automatic op_addr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] r;
    sel(); xb(op, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    sel(); xb(8'h05, r); xb(8'h00, st); desel();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int i = 0; i < 60; i++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic rd(input logic [7:0] op, input logic [23:0] a, input int n);
    logic [7:0] r;
    sel(); xb(op, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
    if (op == 8'h0B) xb(8'h00, r);
    for (int i = 0; i < n; i++) xb(8'h00, rbuf[i]);
    desel();
  endtask

  task automatic prog(input logic [23:0] a, input int n);
    logic [7:0] r;
    op1(8'h06);
    sel(); xb(8'h02, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
    for (int i = 0; i < n; i++) xb(tbuf[i], r);
    desel();
    wait_idle();
  endtask

  task automatic t_reset();
    logic [7:0] st;
    check("R1 miso idle after reset", {7'b0, miso}, 8'h00);
    rdsr(st);
    check("R11 status after reset", st, 8'h00);
  endtask

  task automatic t_ident();
    logic [7:0] r, a, b;
    sel(); xb(8'h9F, r); xb(8'h00, a); xb(8'h00, b); desel();
    check("R10 id type", a, 8'h20);
    check("R10 id capacity", b, 8'h15);
  endtask

  task automatic t_bulk();
    logic [7:0] st, r, a, b;
    op1(8'hC7);
    rdsr(st);
    check("R11 bulk without latch not started", st, 8'h00);
    op1(8'h06);
    rdsr(st);
    check("R11 latch set", st, 8'h02);
    op1(8'hC7);
    rdsr(st);
    check("R9 busy during bulk erase", st, 8'h03);
    sel(); xb(8'h9F, r); xb(8'h00, a); xb(8'h00, b); desel();
    check("R9 id ignored while busy", a, 8'h00);
    check("R9 id ignored while busy 2", b, 8'h00);
    wait_idle();
    rdsr(st);
    check("R11 latch cleared after erase", st, 8'h00);
    rd(8'h03, 24'h000000, 2);
    check("R8 byte 0 erased", rbuf[0], 8'hFF);
    rd(8'h03, 24'h0007FF, 1);
    check("R8 last byte erased", rbuf[0], 8'hFF);
  endtask

  task automatic t_wrap();
    tbuf[0] = 8'hA1; tbuf[1] = 8'hB2; tbuf[2] = 8'hC3; tbuf[3] = 8'hD4; tbuf[4] = 8'hE5;
    prog(24'h0000FE, 5);
    rd(8'h03, 24'h0000FD, 4);
    check("R5 before start untouched", rbuf[0], 8'hFF);
    check("R5 page end 0", rbuf[1], 8'hA1);
    check("R5 page end 1", rbuf[2], 8'hB2);
    check("R5 next page untouched", rbuf[3], 8'hFF);
    rd(8'h03, 24'h000000, 4);
    check("R5 wrapped 0", rbuf[0], 8'hC3);
    check("R5 wrapped 1", rbuf[1], 8'hD4);
    check("R5 wrapped 2", rbuf[2], 8'hE5);
    check("R5 after wrap untouched", rbuf[3], 8'hFF);
  endtask

  task automatic t_and();
    tbuf[0] = 8'h0F;
    prog(24'h000000, 1);
    rd(8'h03, 24'h000000, 2);
    check("R4 and of C3 and 0F", rbuf[0], 8'h03);
    check("R4 neighbour kept", rbuf[1], 8'hD4);
  endtask

  task automatic t_read_wrap();
    rd(8'h03, 24'h0007FF, 2);
    check("R2 last byte", rbuf[0], 8'hFF);
    check("R2 wrap to byte 0", rbuf[1], 8'h03);
    rd(8'h03, 24'hAB0000, 1);
    check("R2 high address bits ignored", rbuf[0], 8'h03);
  endtask

  task automatic t_fast();
    rd(8'h0B, 24'h0000FE, 3);
    check("R3 fast 0", rbuf[0], 8'hA1);
    check("R3 fast 1", rbuf[1], 8'hB2);
    check("R3 fast 2 sequential", rbuf[2], 8'hFF);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 260; k++) tbuf[k] = (k < 4) ? 8'h00 : 8'h77;
    prog(24'h000100, 260);
    rd(8'h03, 24'h000100, 4);
    for (int i = 0; i < 4; i++) check("R6 last bytes kept", rbuf[i], 8'h77);
    rd(8'h03, 24'h0001FF, 1);
    check("R6 page end", rbuf[0], 8'h77);
  endtask

  task automatic t_sector();
    logic [7:0] st, r;
    tbuf[0] = 8'h3C;
    prog(24'h000400, 1);
    op1(8'h06);
    sel(); xb(8'hD8, r); xb(8'h00, r); xb(8'h00, r); xb(8'h00, r); bits(8'h00, 1, r); desel();
    rdsr(st);
    check("R7 misaligned erase not started", st, 8'h02);
    rd(8'h03, 24'h000000, 1);
    check("R7 misaligned erase left data", rbuf[0], 8'h03);
    op_addr(8'hD8, 24'h000123);
    wait_idle();
    rd(8'h03, 24'h000000, 1);
    check("R7 sector byte 0 erased", rbuf[0], 8'hFF);
    rd(8'h03, 24'h0000FE, 1);
    check("R7 sector page 0 erased", rbuf[0], 8'hFF);
    rd(8'h03, 24'h000100, 1);
    check("R7 sector page 1 erased", rbuf[0], 8'hFF);
    rd(8'h03, 24'h000400, 1);
    check("R7 other sector kept", rbuf[0], 8'h3C);
  endtask

  task automatic t_busy_reject();
    logic [7:0] st, r;
    op1(8'h06);
    sel(); xb(8'h02, r); xb(8'h00, r); xb(8'h05, r); xb(8'h00, r); xb(8'h11, r); desel();
    op1(8'h06);
    op_addr(8'hD8, 24'h000400);
    wait_idle();
    rdsr(st);
    check("R13 write enable during cycle ignored", st, 8'h00);
    rd(8'h03, 24'h000400, 1);
    check("R13 erase during cycle ignored", rbuf[0], 8'h3C);
    rd(8'h03, 24'h000500, 1);
    check("R13 running program completed", rbuf[0], 8'h11);
  endtask

  task automatic t_wrsr();
    logic [7:0] st, r;
    op1(8'h06);
    sel(); xb(8'h01, r); xb(8'h9C, r); desel();
    rdsr(st);
    check("R9 busy during status write", {7'b0, st[0]}, 8'h01);
    wait_idle();
    rdsr(st);
    check("R11 status bits stored latch cleared", st, 8'h9C);
  endtask

  task automatic t_sleep();
    logic [7:0] st, r, a;
    op1(8'hB9);
    op1(8'h06);
    rdsr(st);
    check("R12 status read ignored in sleep", st, 8'h00);
    sel(); xb(8'h9F, r); xb(8'h00, a); desel();
    check("R12 id ignored in sleep", a, 8'h00);
    op1(8'hAB);
    rdsr(st);
    check("R12 release, write enable was ignored", st, 8'h9C);
    sel(); xb(8'h9F, r); xb(8'h00, a); desel();
    check("R12 id after release", a, 8'h20);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ident();
    t_bulk();
    t_wrap();
    t_and();
    t_read_wrap();
    t_fast();
    t_overflow();
    t_sector();
    t_busy_reject();
    t_wrsr();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule